// File: doc/BRIEF.md
# Self-Timed Page Write Sequencer

This block sits behind the serial front end of a non-volatile memory and handles the array write command. It receives the start address and the data bytes of the command. It stores them in a one-page staging buffer, together with a mask of which buffer slots were filled. When chip select rises on a clean byte boundary, it runs a self-timed programming cycle. The cycle first commits every filled, unprotected slot to the array, one slot per clock. It then waits out a programmed dwell time. During the whole cycle the block reports busy and forces the status byte it passes through to all ones. When the cycle ends, it pulses a request that clears the write-enable latch.

The state machine has six states. IDLE waits for a command. DISCARD swallows a command issued with the latch clear. ADDR waits for the start address. COLLECT fills the page buffer. COMMIT steps through the page slots and drives the array port. WAIT counts the dwell time.

The transitions are as follows:
- IDLE goes to ADDR on a command with the latch set, and to DISCARD on a command with the latch clear.
- DISCARD returns to IDLE on a chip-select rise.
- ADDR goes to COLLECT when the address arrives. It returns to IDLE on a chip-select rise.
- COLLECT goes to COMMIT on a chip-select rise that is on a byte boundary, provided at least one byte was received. It returns to IDLE on any other chip-select rise.
- COMMIT goes to WAIT after the last slot.
- WAIT returns to IDLE when the dwell counter expires.

Top module: `page_write_seq`

## Requirements
- R1: A write command seen while `wel_i` is 0 causes no array write, no busy period and no latch-clear pulse; the block waits for the next chip-select rise and is idle again afterwards.
- R2: The first data byte goes to the start address. Each further byte goes to the next address, with only the low log2(PAGE_BYTES) address bits advancing and the upper bits held. The low bits wrap from the last slot of the page back to slot 0.
- R3: When more than PAGE_BYTES bytes are sent, a later byte that lands on an already filled slot replaces the earlier byte, and only the final value is programmed.
- R4: A chip-select rise with `mid_byte_i` = 1 (a partial byte was clocked in) abandons the command: no array write and no busy period.
- R5: A chip-select rise after the address but before any data byte abandons the command without a cycle.
- R6: `busy_o` goes high in the cycle after a qualifying chip-select rise. It stays high for exactly PAGE_BYTES + TWC_CYCLES cycles.
- R7: While busy, `stat_o` is 8'hFF. Otherwise it equals `stat_in_i` with bit 0 forced to 0.
- R8: `wel_clr_o` pulses for exactly one cycle at the end of each programming cycle, and `busy_o` is low in the following cycle.
- R9: No byte is written at an address that is protected under `prot_lvl_i`. The levels are: 0 protects nothing; 1 protects addresses whose two top bits are both 1 (top quarter); 2 protects addresses whose top bit is 1 (top half); 3 protects every address.
- R10: Commands, addresses, bytes and chip-select rises arriving while busy are ignored and do not lengthen the cycle.
- R11: Only page slots that received a byte are written; other locations of the page are left untouched.
- R12: After reset the block is idle, with `busy_o` = 0, `mem_we_o` = 0 and `wel_clr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_cmd_i | input | 1 | One-cycle strobe: array write opcode decoded |
| addr_vld_i | input | 1 | One-cycle strobe: start address complete |
| addr_i | input | ADDR_W | Start address |
| byte_vld_i | input | 1 | One-cycle strobe: data byte complete |
| byte_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | One-cycle strobe: chip select deasserted |
| mid_byte_i | input | 1 | A partial byte is in the shifter at chip-select rise |
| wel_i | input | 1 | Write-enable latch state |
| prot_lvl_i | input | 2 | Block protection level |
| stat_in_i | input | 8 | Status byte from the status register |
| stat_o | output | 8 | Status byte as seen by the host |
| busy_o | output | 1 | Programming cycle in progress |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The bench targets page wrap and overflow. It starts a command near the end of a page and sends more bytes than a page holds. An address counter that carried into the upper bits would write into the next page, and a buffer that kept first values would leave stale data. Abandon paths (a partial byte, no data, a clear latch) are checked at the array port: a design that started anyway would show write strobes and a busy period. The bench also checks protection levels on pages inside and outside the guarded range, and strobes sent during busy. A wrong decode would write guarded bytes, and a leaky busy gate would write the late bytes or stretch the busy length away from page size plus dwell.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCARD,
        ST_ADDR,
        ST_COLLECT,
        ST_COMMIT,
        ST_WAIT
    } pws_state_e;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'd0,
        PROT_QUARTER = 2'd1,
        PROT_HALF    = 2'd2,
        PROT_ALL     = 2'd3
    } prot_lvl_e;

endpackage

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [7:0]               wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [7:0]               rd_data,
    output logic                     rd_valid,
    output logic                     any_valid
);
    logic [7:0]       slot_q [DEPTH];
    logic [DEPTH-1:0] fill_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fill_q[g] <= 1'b0;
                slot_q[g] <= '0;
            end else if (clr) begin
                fill_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == g) begin
                fill_q[g] <= 1'b1;
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data   = slot_q[rd_idx];
    assign rd_valid  = fill_q[rd_idx];
    assign any_valid = |fill_q;
endmodule

// File: rtl/pws_prot_check.sv
module pws_prot_check
    import pws_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lvl,
    output logic              hit
);
    always_comb begin
        unique case (prot_lvl_e'(lvl))
            PROT_NONE:    hit = 1'b0;
            PROT_QUARTER: hit = &addr[ADDR_W-1:ADDR_W-2];
            PROT_HALF:    hit = addr[ADDR_W-1];
            PROT_ALL:     hit = 1'b1;
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/pws_dwell_timer.sv
module pws_dwell_timer #(
    parameter int LIMIT = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign done = run_q && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64,
    parameter int TWC_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              cs_rise_i,
    input  logic              mid_byte_i,
    input  logic              wel_i,
    input  logic [1:0]        prot_lvl_i,
    input  logic [7:0]        stat_in_i,
    output logic [7:0]        stat_o,
    output logic              busy_o,
    output logic              wel_clr_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);

    pws_state_e state_q, state_d;

    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  idx_q;

    logic       buf_clr, buf_wr;
    logic [7:0] rd_data;
    logic       rd_valid, any_valid;
    logic       prot_hit;
    logic       tmr_start, tmr_done;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (wr_cmd_i) state_d = wel_i ? ST_ADDR : ST_DISCARD;
            ST_DISCARD:
                if (cs_rise_i) state_d = ST_IDLE;
            ST_ADDR:
                if (cs_rise_i)       state_d = ST_IDLE;
                else if (addr_vld_i) state_d = ST_COLLECT;
            ST_COLLECT:
                if (cs_rise_i)
                    state_d = (!mid_byte_i && any_valid) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT:
                if (idx_q == LAST_SLOT) state_d = ST_WAIT;
            ST_WAIT:
                if (tmr_done) state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy_o     = (state_q == ST_COMMIT) || (state_q == ST_WAIT);
        buf_clr    = (state_q == ST_IDLE) && wr_cmd_i && wel_i;
        buf_wr     = (state_q == ST_COLLECT) && byte_vld_i && !cs_rise_i;
        mem_we_o   = (state_q == ST_COMMIT) && rd_valid && !prot_hit;
        mem_addr_o = {page_q, idx_q};
        mem_data_o = rd_data;
        tmr_start  = (state_q == ST_COMMIT) && (idx_q == LAST_SLOT);
        wel_clr_o  = (state_q == ST_WAIT) && tmr_done;
        stat_o     = busy_o ? 8'hFF : {stat_in_i[7:1], 1'b0};
    end

    // ---------------- address datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (state_q == ST_ADDR && addr_vld_i && !cs_rise_i) begin
                page_q <= addr_i[ADDR_W-1:OFF_W];
                off_q  <= addr_i[OFF_W-1:0];
            end else if (buf_wr) begin
                off_q <= off_q + 1'b1;
            end
            if (state_q == ST_COMMIT) idx_q <= idx_q + 1'b1;
            else                      idx_q <= '0;
        end
    end

    pws_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_idx    (off_q),
        .wr_data   (byte_i),
        .rd_idx    (idx_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pws_prot_check #(.ADDR_W(ADDR_W)) u_prot (
        .addr (mem_addr_o),
        .lvl  (prot_lvl_i),
        .hit  (prot_hit)
    );

    pws_dwell_timer #(.LIMIT(TWC_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise_i,
    input logic [1:0]        prot_lvl_i,
    input logic [7:0]        stat_o,
    input logic              busy_o,
    input logic              wel_clr_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    logic guarded;
    always_comb begin
        guarded = (prot_lvl_i == 2'd3)
               || (prot_lvl_i == 2'd2 && mem_addr_o[ADDR_W-1])
               || (prot_lvl_i == 2'd1 && mem_addr_o[ADDR_W-1] && mem_addr_o[ADDR_W-2]);
    end

    a_r6_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise_i));
    a_r7_status_ones: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> stat_o == 8'hFF);
    a_r8_clear_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |=> !busy_o);
    a_r8_clear_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> busy_o);
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wel_clr_o) |=> busy_o);
    a_r9_no_guarded_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !guarded);
    a_r1_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
endmodule

bind page_write_seq pws_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise_i  (cs_rise_i),
    .prot_lvl_i (prot_lvl_i),
    .stat_o     (stat_o),
    .busy_o     (busy_o),
    .wel_clr_o  (wel_clr_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/tb_page_write_seq.sv
module tb_page_write_seq;
    localparam int AW    = 10;
    localparam int PAGE  = 64;
    localparam int TWC   = 40;
    localparam int MSIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_cmd_i = 0, addr_vld_i = 0, byte_vld_i = 0, cs_rise_i = 0, mid_byte_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    byte_i = '0;
    logic          wel_i = 0;
    logic [1:0]    prot_lvl_i = 2'd0;
    logic [7:0]    stat_in_i = 8'h5B;
    logic [7:0]    stat_o;
    logic          busy_o, wel_clr_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_data_o;

    int checks = 0, fails = 0;
    int busy_cyc = 0, clr_cnt = 0, we_cnt = 0, cyc = 0;
    logic [7:0] arr [MSIZE];
    logic [7:0] exp_arr [MSIZE];

    always #10 clk = ~clk;

    page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PAGE), .TWC_CYCLES(TWC)) dut (.*);

    // array model and observation counters, sampled away from the rising edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy_o) busy_cyc++;
            if (wel_clr_o) begin clr_cnt++; wel_i = 1'b0; end
            if (mem_we_o) begin we_cnt++; arr[mem_addr_o] = mem_data_o; end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit guarded(input int a, input int lvl);
        case (lvl)
            1: return a >= 3 * MSIZE / 4;
            2: return a >= MSIZE / 2;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic compare_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MSIZE; i++)
            if (arr[i] !== exp_arr[i]) begin bad++; if (first < 0) first = i; end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: %0d locations differ, first at %0d actual %0d expected %0d",
                     req, bad, first, arr[first], exp_arr[first]);
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk) wr_cmd_i = 1; @(negedge clk) wr_cmd_i = 0;
    endtask
    task automatic pulse_addr(input int a);
        @(negedge clk) begin addr_i = AW'(a); addr_vld_i = 1; end
        @(negedge clk) addr_vld_i = 0;
    endtask
    task automatic pulse_byte(input logic [7:0] b);
        @(negedge clk) begin byte_i = b; byte_vld_i = 1; end
        @(negedge clk) byte_vld_i = 0;
    endtask
    task automatic pulse_cs(input logic mid);
        @(negedge clk) begin cs_rise_i = 1; mid_byte_i = mid; end
        @(negedge clk) begin cs_rise_i = 0; mid_byte_i = 0; end
    endtask
    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask
    task automatic clear_counts();
        busy_cyc = 0; clr_cnt = 0; we_cnt = 0;
    endtask

    // full write with model update; base is start address, n bytes from seed
    task automatic write_run(input int base, input int n, input int seed, input int lvl);
        int pg = base & ~(PAGE - 1);
        int off = base & (PAGE - 1);
        prot_lvl_i = 2'(lvl);
        wel_i = 1'b1;
        clear_counts();
        pulse_cmd();
        pulse_addr(base);
        for (int k = 0; k < n; k++) begin
            int a = pg | ((off + k) & (PAGE - 1));
            pulse_byte(8'(seed + k));
            if (!guarded(a, lvl)) exp_arr[a] = 8'(seed + k);
        end
        pulse_cs(1'b0);
        chk("R7 status all ones while busy", stat_o, 8'hFF);
        wait_idle();
        chk("R6 busy length", busy_cyc, PAGE + TWC);
        chk("R8 one latch-clear pulse", clr_cnt, 1);
    endtask

    task automatic t_reset();
        chk("R12 busy after reset", busy_o, 0);
        chk("R12 write strobe after reset", mem_we_o, 0);
        chk("R12 latch clear after reset", wel_clr_o, 0);
        chk("R7 idle status passes with bit0 low", stat_o, 8'h5A);
    endtask

    task automatic t_no_latch();
        wel_i = 1'b0; clear_counts();
        pulse_cmd(); pulse_addr(12'h040);
        pulse_byte(8'hA1); pulse_byte(8'hA2);
        pulse_cs(1'b0);
        repeat (PAGE + 4) @(negedge clk);
        chk("R1 no writes without latch", we_cnt, 0);
        chk("R1 no busy without latch", busy_cyc, 0);
        chk("R1 no clear pulse without latch", clr_cnt, 0);
        compare_mem("R1 array untouched");
    endtask

    task automatic t_basic();
        write_run(12'h07C, 6, 8'h10, 0);
        compare_mem("R2 R11 wrap inside page, untouched slots kept");
        chk("R7 status after cycle", stat_o, 8'h5A);
    endtask

    task automatic t_overflow();
        write_run(12'h080, PAGE + 2, 8'h20, 0);
        compare_mem("R3 overflow overwrites earliest slots");
    endtask

    task automatic t_mid_byte();
        wel_i = 1'b1; clear_counts();
        pulse_cmd(); pulse_addr(12'h0C0);
        pulse_byte(8'h77); pulse_byte(8'h78);
        pulse_cs(1'b1);
        repeat (PAGE + 4) @(negedge clk);
        chk("R4 mid-byte rise no writes", we_cnt, 0);
        chk("R4 mid-byte rise no busy", busy_cyc, 0);
        compare_mem("R4 array untouched");
    endtask

    task automatic t_no_data();
        wel_i = 1'b1; clear_counts();
        pulse_cmd(); pulse_addr(12'h100);
        pulse_cs(1'b0);
        repeat (PAGE + 4) @(negedge clk);
        chk("R5 no-data rise no busy", busy_cyc, 0);
        chk("R5 no-data rise no clear", clr_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        wel_i = 1'b1; clear_counts();
        prot_lvl_i = 2'd0;
        pulse_cmd(); pulse_addr(12'h140);
        pulse_byte(8'h31); exp_arr[12'h140] = 8'h31;
        pulse_cs(1'b0);
        pulse_cmd(); pulse_addr(12'h180);
        pulse_byte(8'hEE); pulse_byte(8'hEF);
        pulse_cs(1'b0);
        wait_idle();
        chk("R10 busy not extended", busy_cyc, PAGE + TWC);
        chk("R10 only one write", we_cnt, 1);
        compare_mem("R10 bytes during busy ignored");
    endtask

    task automatic t_protect();
        write_run(12'h240, 4, 8'h50, 2);
        chk("R9 half level blocks upper half", we_cnt, 0);
        write_run(12'h280, 4, 8'h60, 1);
        chk("R9 quarter level allows below top quarter", we_cnt, 4);
        write_run(12'h3C0, 4, 8'h68, 1);
        chk("R9 quarter level blocks top quarter", we_cnt, 0);
        write_run(12'h000, 4, 8'h70, 3);
        chk("R9 full level blocks all", we_cnt, 0);
        compare_mem("R9 array after protected runs");
    endtask

    initial begin
        for (int i = 0; i < MSIZE; i++) begin arr[i] = 8'h00; exp_arr[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_latch();
        t_basic();
        t_overflow();
        t_mid_byte();
        t_no_data();
        t_busy_ignore();
        t_protect();
        finish_run();
    end
endmodule